// File: doc/BRIEF.md
# Separate-port quad-rate SRAM controller port (burst of two)

This block sits between user logic and a quad-data-rate static RAM that has one write-data port, one read-data port and a single address bus that both operations share. User logic raises a read request, a write request, or both in the same clock. The block turns them into active-low read-select and write-select strobes and a time-shared address. A write word is split into two halves with byte-lane selects for the two data phases of the clock. Read data is captured at a fixed latency, reassembled into a full word and handed back with a one-cycle valid pulse.

Every double-rate pin is shown as a pair of registered outputs: a `_hi` value for the rising half of the clock and a `_lo` value for the falling half. Read data comes in the same way. These pairs feed the chip's double-rate I/O cells. With `BURST` = 2 the read address takes the rising half and the write address the falling half, so a read and a write leave together. With `BURST` = 4 the memory takes both addresses on the rising edge. A write that meets a read in the same clock is then refused for that clock through `usr_wr_stall`, and the user holds it for a later cycle.

Top module: `qsram_port_ctl`

## Requirements
- R1: While `rst_n` is low, both select outputs are 1, every byte-write select is 1, addresses, write data and read data are 0, and `usr_rd_valid` is 0.
- R2: A read request sampled at a rising edge drives `mem_rps_n` to 0 and puts its address on `mem_addr_hi` after that edge, in both modes.
- R3: In burst-of-two mode, a write request sampled at a rising edge drives `mem_wps_n` to 0 and puts its address on `mem_addr_lo` after that edge.
- R4: An accepted write puts `usr_wr_data[HALF_W-1:0]` on `mem_d_hi` and the upper half on `mem_d_lo`. Each byte-write select is the inverse of its enable: `usr_wr_be[NBW-1:0]` goes to `mem_bws_n_hi` and the upper bits to `mem_bws_n_lo`. In cycles with no write, all byte-write selects are 1.
- R5: In burst-of-two mode, a read and a write requested in the same clock are both issued in the following cycle, including when both carry the same address.
- R6: In a cycle with no request of a kind, that select output is 1 and the address output it owns keeps its last value. Write data keeps its last value when no write is accepted.
- R7: `mem_q_hi`/`mem_q_lo` are sampled at the rising edge `RD_LAT` clocks after the one that accepted the read. In the cycle that follows, `usr_rd_valid` is 1 for one clock and `usr_rd_data` = {`mem_q_lo`, `mem_q_hi`}. Otherwise `usr_rd_data` holds.
- R8: Reads in consecutive clocks each produce their own valid pulse, in request order, in consecutive cycles.
- R9: In burst-of-four mode, the one address is driven on both `mem_addr_hi` and `mem_addr_lo`. When a read and a write are requested together, `usr_wr_stall` is 1 in that clock, the read is issued and the write is not.
- R10: In burst-of-two mode, `usr_wr_stall` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_rd_req | input | 1 | Read request for this clock |
| usr_rd_addr | input | ADDR_W | Read address |
| usr_wr_req | input | 1 | Write request for this clock |
| usr_wr_addr | input | ADDR_W | Write address |
| usr_wr_data | input | 2*HALF_W | Write word, lower half sent first |
| usr_wr_be | input | 2*NBW | Active-high byte-lane enables, lower group for the first half |
| usr_wr_stall | output | 1 | Write refused this clock (burst-of-four collision only) |
| usr_rd_data | output | 2*HALF_W | Reassembled read word |
| usr_rd_valid | output | 1 | One-cycle read-data valid pulse |
| mem_rps_n | output | 1 | Active-low read select |
| mem_wps_n | output | 1 | Active-low write select |
| mem_addr_hi | output | ADDR_W | Address for the rising half of the clock |
| mem_addr_lo | output | ADDR_W | Address for the falling half of the clock |
| mem_d_hi | output | HALF_W | Write data, rising half |
| mem_d_lo | output | HALF_W | Write data, falling half |
| mem_bws_n_hi | output | NBW | Active-low byte-write selects, rising half |
| mem_bws_n_lo | output | NBW | Active-low byte-write selects, falling half |
| mem_q_hi | input | HALF_W | Read data captured on the rising half |
| mem_q_lo | input | HALF_W | Read data captured on the falling half |

## Verification
The hardest case to reach from the ports combines three things: a read and a write to the same address in one clock, reads already in flight, and the returning data meeting new requests. Directed cycles first issue a same-address read and write together, then three reads back to back. A long random phase follows with independent request probabilities, so collisions, idle gaps and overlapping returns all occur. The same stimulus goes to a burst-of-two and a burst-of-four instance. The stall path and the single-edge address are then tested against the collisions that the burst-of-two instance absorbs.

// File: rtl/qsram_pkg.sv
package qsram_pkg;
   localparam int unsigned LANE_W = 9;
   localparam int unsigned BL2    = 2;
   localparam int unsigned BL4    = 4;
   localparam logic        SEL_ON  = 1'b0;
   localparam logic        SEL_OFF = 1'b1;
endpackage

// File: rtl/qsram_cmd_seq.sv
module qsram_cmd_seq #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned BURST  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              wr_take,
   output logic              wr_stall,
   output logic              rps_n,
   output logic              wps_n,
   output logic [ADDR_W-1:0] addr_hi,
   output logic [ADDR_W-1:0] addr_lo
);
   import qsram_pkg::*;

   generate
      if (BURST == BL2) begin : g_two_edge
         logic [ADDR_W-1:0] a_rise_q, a_fall_q;
         assign wr_stall = 1'b0;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               a_rise_q <= '0;
               a_fall_q <= '0;
            end else begin
               if (rd_req) a_rise_q <= rd_addr;
               if (wr_req) a_fall_q <= wr_addr;
            end
         end
         assign addr_hi = a_rise_q;
         assign addr_lo = a_fall_q;
      end else begin : g_one_edge
         logic [ADDR_W-1:0] a_one_q;
         assign wr_stall = rd_req & wr_req;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               a_one_q <= '0;
            end else if (rd_req) begin
               a_one_q <= rd_addr;
            end else if (wr_req) begin
               a_one_q <= wr_addr;
            end
         end
         assign addr_hi = a_one_q;
         assign addr_lo = a_one_q;
      end
   endgenerate

   assign wr_take = wr_req & ~wr_stall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rps_n <= SEL_OFF;
         wps_n <= SEL_OFF;
      end else begin
         rps_n <= rd_req  ? SEL_ON : SEL_OFF;
         wps_n <= wr_take ? SEL_ON : SEL_OFF;
      end
   end
endmodule

// File: rtl/qsram_wr_lanes.sv
module qsram_wr_lanes #(
   parameter int unsigned HALF_W = 18,
   parameter int unsigned NBW    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [2*HALF_W-1:0] wr_data,
   input  logic [2*NBW-1:0]    wr_be,
   output logic [HALF_W-1:0]   d_hi,
   output logic [HALF_W-1:0]   d_lo,
   output logic [NBW-1:0]      bws_n_hi,
   output logic [NBW-1:0]      bws_n_lo
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_hi <= '0;
         d_lo <= '0;
      end else if (take) begin
         d_hi <= wr_data[HALF_W-1:0];
         d_lo <= wr_data[2*HALF_W-1:HALF_W];
      end
   end

   for (genvar g = 0; g < NBW; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bws_n_hi[g] <= 1'b1;
            bws_n_lo[g] <= 1'b1;
         end else begin
            bws_n_hi[g] <= ~(take & wr_be[g]);
            bws_n_lo[g] <= ~(take & wr_be[NBW+g]);
         end
      end
   end
endmodule

// File: rtl/qsram_rd_capture.sv
module qsram_rd_capture #(
   parameter int unsigned HALF_W = 18,
   parameter int unsigned RD_LAT = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue,
   input  logic [HALF_W-1:0]   q_hi,
   input  logic [HALF_W-1:0]   q_lo,
   output logic [2*HALF_W-1:0] rd_data,
   output logic                rd_valid
);
   logic [RD_LAT-1:0] pend_q;

   generate
      if (RD_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= '0;
            else        pend_q <= issue;
         end
      end else begin : g_lat_many
         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= '0;
            else        pend_q <= {pend_q[RD_LAT-2:0], issue};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= pend_q[RD_LAT-1];
         if (pend_q[RD_LAT-1]) rd_data <= {q_lo, q_hi};
      end
   end
endmodule

// File: rtl/qsram_port_ctl.sv
module qsram_port_ctl #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned HALF_W = 18,
   parameter int unsigned BURST  = 2,
   parameter int unsigned RD_LAT = 3,
   localparam int unsigned NBW   = HALF_W / qsram_pkg::LANE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                usr_rd_req,
   input  logic [ADDR_W-1:0]   usr_rd_addr,
   input  logic                usr_wr_req,
   input  logic [ADDR_W-1:0]   usr_wr_addr,
   input  logic [2*HALF_W-1:0] usr_wr_data,
   input  logic [2*NBW-1:0]    usr_wr_be,
   output logic                usr_wr_stall,
   output logic [2*HALF_W-1:0] usr_rd_data,
   output logic                usr_rd_valid,
   output logic                mem_rps_n,
   output logic                mem_wps_n,
   output logic [ADDR_W-1:0]   mem_addr_hi,
   output logic [ADDR_W-1:0]   mem_addr_lo,
   output logic [HALF_W-1:0]   mem_d_hi,
   output logic [HALF_W-1:0]   mem_d_lo,
   output logic [NBW-1:0]      mem_bws_n_hi,
   output logic [NBW-1:0]      mem_bws_n_lo,
   input  logic [HALF_W-1:0]   mem_q_hi,
   input  logic [HALF_W-1:0]   mem_q_lo
);
   import qsram_pkg::*;

   generate
      if (HALF_W % LANE_W != 0) begin : g_bad_width
         $error("HALF_W must be a whole number of 9-bit lanes");
      end
      if (BURST != BL2 && BURST != BL4) begin : g_bad_burst
         $error("BURST must be 2 or 4");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic wr_take;

   qsram_cmd_seq #(.ADDR_W(ADDR_W), .BURST(BURST)) cmd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (usr_rd_req),
      .rd_addr  (usr_rd_addr),
      .wr_req   (usr_wr_req),
      .wr_addr  (usr_wr_addr),
      .wr_take  (wr_take),
      .wr_stall (usr_wr_stall),
      .rps_n    (mem_rps_n),
      .wps_n    (mem_wps_n),
      .addr_hi  (mem_addr_hi),
      .addr_lo  (mem_addr_lo)
   );

   qsram_wr_lanes #(.HALF_W(HALF_W), .NBW(NBW)) wr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (wr_take),
      .wr_data  (usr_wr_data),
      .wr_be    (usr_wr_be),
      .d_hi     (mem_d_hi),
      .d_lo     (mem_d_lo),
      .bws_n_hi (mem_bws_n_hi),
      .bws_n_lo (mem_bws_n_lo)
   );

   qsram_rd_capture #(.HALF_W(HALF_W), .RD_LAT(RD_LAT)) rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (usr_rd_req),
      .q_hi     (mem_q_hi),
      .q_lo     (mem_q_lo),
      .rd_data  (usr_rd_data),
      .rd_valid (usr_rd_valid)
   );
endmodule

// File: rtl/qsram_port_chk.sv
module qsram_port_chk #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned NBW    = 2,
   parameter int unsigned BURST  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              usr_rd_req,
   input logic              usr_wr_req,
   input logic              usr_wr_stall,
   input logic              usr_rd_valid,
   input logic              mem_rps_n,
   input logic              mem_wps_n,
   input logic [ADDR_W-1:0] mem_addr_hi,
   input logic [ADDR_W-1:0] mem_addr_lo,
   input logic [NBW-1:0]    mem_bws_n_hi,
   input logic [NBW-1:0]    mem_bws_n_lo
);
   logic [15:0] inflight_q;

   always_ff @(posedge clk) begin
      if (!rst_n) inflight_q <= '0;
      else        inflight_q <= inflight_q + 16'(!mem_rps_n) - 16'(usr_rd_valid);
   end

   p_rd_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rd_req |=> !mem_rps_n);

   p_wr_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_wr_req && !usr_wr_stall) |=> !mem_wps_n);

   p_bws_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wps_n |-> ((&mem_bws_n_hi) && (&mem_bws_n_lo)));

   p_both_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (BURST == 2 && usr_rd_req && usr_wr_req) |=> (!mem_rps_n && !mem_wps_n));

   p_rd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_rd_req |=> mem_rps_n);

   p_wr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_wr_req |=> mem_wps_n);

   p_fall_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (BURST == 2 && !usr_wr_req) |=> $stable(mem_addr_lo));

   p_valid_has_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rd_valid |-> (inflight_q != 16'd0));

   p_collide_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (BURST == 4 && usr_rd_req && usr_wr_req) |=> (mem_wps_n && !mem_rps_n));

   p_one_edge_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (BURST == 4 && !mem_wps_n) |-> (mem_addr_hi == mem_addr_lo));
endmodule

bind qsram_port_ctl qsram_port_chk #(
   .ADDR_W(ADDR_W), .NBW(NBW), .BURST(BURST)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .usr_rd_req   (usr_rd_req),
   .usr_wr_req   (usr_wr_req),
   .usr_wr_stall (usr_wr_stall),
   .usr_rd_valid (usr_rd_valid),
   .mem_rps_n    (mem_rps_n),
   .mem_wps_n    (mem_wps_n),
   .mem_addr_hi  (mem_addr_hi),
   .mem_addr_lo  (mem_addr_lo),
   .mem_bws_n_hi (mem_bws_n_hi),
   .mem_bws_n_lo (mem_bws_n_lo)
);

// File: tb/qsram_port_ctl_tb_top.sv
module qsram_port_ctl_tb_top;
   localparam int AW  = 19;
   localparam int HW  = 18;
   localparam int NB  = 2;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          rd_req = 0, wr_req = 0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [2*HW-1:0] wr_data = '0;
   logic [2*NB-1:0] wr_be = '0;
   logic [HW-1:0] q_hi = '0, q_lo = '0;

   logic            stall [2];
   logic [2*HW-1:0] rdat  [2];
   logic            rval  [2];
   logic            rps_n [2];
   logic            wps_n [2];
   logic [AW-1:0]   ahi   [2];
   logic [AW-1:0]   alo   [2];
   logic [HW-1:0]   dhi   [2];
   logic [HW-1:0]   dlo   [2];
   logic [NB-1:0]   bhi   [2];
   logic [NB-1:0]   blo   [2];

   qsram_port_ctl #(.ADDR_W(AW), .HALF_W(HW), .BURST(2), .RD_LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .usr_rd_req(rd_req), .usr_rd_addr(rd_addr),
      .usr_wr_req(wr_req), .usr_wr_addr(wr_addr),
      .usr_wr_data(wr_data), .usr_wr_be(wr_be),
      .usr_wr_stall(stall[0]), .usr_rd_data(rdat[0]), .usr_rd_valid(rval[0]),
      .mem_rps_n(rps_n[0]), .mem_wps_n(wps_n[0]),
      .mem_addr_hi(ahi[0]), .mem_addr_lo(alo[0]),
      .mem_d_hi(dhi[0]), .mem_d_lo(dlo[0]),
      .mem_bws_n_hi(bhi[0]), .mem_bws_n_lo(blo[0]),
      .mem_q_hi(q_hi), .mem_q_lo(q_lo));

   qsram_port_ctl #(.ADDR_W(AW), .HALF_W(HW), .BURST(4), .RD_LAT(LAT)) dut4_i (
      .clk(clk), .rst_n(rst_n),
      .usr_rd_req(rd_req), .usr_rd_addr(rd_addr),
      .usr_wr_req(wr_req), .usr_wr_addr(wr_addr),
      .usr_wr_data(wr_data), .usr_wr_be(wr_be),
      .usr_wr_stall(stall[1]), .usr_rd_data(rdat[1]), .usr_rd_valid(rval[1]),
      .mem_rps_n(rps_n[1]), .mem_wps_n(wps_n[1]),
      .mem_addr_hi(ahi[1]), .mem_addr_lo(alo[1]),
      .mem_d_hi(dhi[1]), .mem_d_lo(dlo[1]),
      .mem_bws_n_hi(bhi[1]), .mem_bws_n_lo(blo[1]),
      .mem_q_hi(q_hi), .mem_q_lo(q_lo));

   int checks = 0, errors = 0, edge_no = 0, pulses = 0;
   bit done = 0;

   logic            x_rps [2], x_wps [2], x_val;
   logic [AW-1:0]   x_ahi [2], x_alo [2];
   logic [HW-1:0]   x_dhi [2], x_dlo [2];
   logic [NB-1:0]   x_bhi [2], x_blo [2];
   logic [2*HW-1:0] x_dat;

   logic [2*HW-1:0] mem_m [int unsigned];
   int              due_q [$];
   logic [2*HW-1:0] word_q [$];

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic reset_expect();
      for (int m = 0; m < 2; m++) begin
         x_rps[m] = 1; x_wps[m] = 1; x_ahi[m] = '0; x_alo[m] = '0;
         x_dhi[m] = '0; x_dlo[m] = '0; x_bhi[m] = '1; x_blo[m] = '1;
      end
      x_val = 0; x_dat = '0;
   endtask

   task automatic compare_all();
      for (int m = 0; m < 2; m++) begin
         chk("R2", "rps_n", 64'(rps_n[m]), 64'(x_rps[m]));
         chk("R2", "addr_hi", 64'(ahi[m]), 64'(x_ahi[m]));
         chk(m == 0 ? "R3" : "R9", "wps_n", 64'(wps_n[m]), 64'(x_wps[m]));
         chk(m == 0 ? "R3" : "R9", "addr_lo", 64'(alo[m]), 64'(x_alo[m]));
         chk("R4", "d_hi", 64'(dhi[m]), 64'(x_dhi[m]));
         chk("R4", "d_lo", 64'(dlo[m]), 64'(x_dlo[m]));
         chk("R4", "bws_hi", 64'(bhi[m]), 64'(x_bhi[m]));
         chk("R4", "bws_lo", 64'(blo[m]), 64'(x_blo[m]));
         chk("R7", "rd_valid", 64'(rval[m]), 64'(x_val));
         chk("R7", "rd_data", 64'(rdat[m]), 64'(x_dat));
      end
      if (rval[0] === 1'b1) pulses++;
   endtask

   task automatic step(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                       logic [2*HW-1:0] wd, logic [2*NB-1:0] be);
      @(negedge clk);
      compare_all();
      rd_req = rd; rd_addr = ra; wr_req = wr; wr_addr = wa; wr_data = wd; wr_be = be;
      for (int m = 0; m < 2; m++) begin
         bit take;
         take = wr && !(m == 1 && rd);
         x_rps[m] = !rd;
         x_wps[m] = !take;
         if (m == 0) begin
            if (rd) x_ahi[0] = ra;
            if (wr) x_alo[0] = wa;
         end else begin
            if (rd) x_ahi[1] = ra;
            else if (wr) x_ahi[1] = wa;
            x_alo[1] = x_ahi[1];
         end
         if (take) begin
            x_dhi[m] = wd[HW-1:0]; x_dlo[m] = wd[2*HW-1:HW];
            x_bhi[m] = ~be[NB-1:0]; x_blo[m] = ~be[2*NB-1:NB];
         end else begin
            x_bhi[m] = '1; x_blo[m] = '1;
         end
      end
      if (rd) begin
         due_q.push_back(edge_no + LAT);
         word_q.push_back(mem_m.exists(int'(ra)) ? mem_m[int'(ra)] : '0);
      end
      if (wr) mem_m[int'(wa)] = wd;
      if (due_q.size() > 0 && due_q[0] == edge_no) begin
         logic [2*HW-1:0] w;
         w = word_q.pop_front();
         void'(due_q.pop_front());
         q_hi = w[HW-1:0]; q_lo = w[2*HW-1:HW];
         x_val = 1; x_dat = w;
      end else begin
         q_hi = HW'($urandom); q_lo = HW'($urandom);
         x_val = 0;
      end
      edge_no++;
      #1;
      chk("R10", "stall b2", 64'(stall[0]), 64'(0));
      chk("R9", "stall b4", 64'(stall[1]), 64'(rd && wr));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, '0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      reset_expect();
      repeat (3) @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         chk("R1", "reset rps_n", 64'(rps_n[m]), 64'(1));
         chk("R1", "reset wps_n", 64'(wps_n[m]), 64'(1));
         chk("R1", "reset bws", 64'({bhi[m], blo[m]}), 64'(4'hF));
         chk("R1", "reset valid", 64'(rval[m]), 64'(0));
         chk("R1", "reset addr", 64'({ahi[m], alo[m]}), 64'(0));
      end
      rst_n = 1;

      step(0, '0, 1, 19'h00012, 36'hA_BCDE_F123, 4'b1111);
      step(0, '0, 1, 19'h00034, 36'h1_2345_6789, 4'b0110);
      step(1, 19'h00012, 0, '0, '0, '0);
      idle(1);
      chk("R6", "addr_lo held after idle", 64'(alo[0]), 64'(19'h00034));
      chk("R6", "d_lo held after idle", 64'(dlo[0]), 64'(18'h0_48D1));
      step(1, 19'h00034, 1, 19'h00034, 36'hF_0F0F_0F0F, 4'b1001);
      step(0, '0, 0, '0, '0, '0);
      chk("R5", "same-address read issued", 64'(rps_n[0]), 64'(0));
      chk("R5", "same-address write issued", 64'(wps_n[0]), 64'(0));
      chk("R9", "b4 write deferred", 64'(wps_n[1]), 64'(1));
      idle(LAT + 2);

      pulses = 0;
      step(1, 19'h00012, 0, '0, '0, '0);
      step(1, 19'h00034, 0, '0, '0, '0);
      step(1, 19'h00077, 0, '0, '0, '0);
      idle(LAT + 3);
      chk("R8", "pulses for three reads", 64'(pulses), 64'(3));

      for (int i = 0; i < 600; i++) begin
         bit rd, wr;
         rd = ($urandom % 100) < 45;
         wr = ($urandom % 100) < 45;
         step(rd, AW'($urandom % 24), wr, AW'($urandom % 24),
              {$urandom, 4'($urandom)}, 4'($urandom));
      end
      idle(LAT + 3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule